// File: doc/BRIEF.md
# Streaming Rank-Order Filter

This block filters a stream of samples through a sliding window of `2*HALF_WIN+1` entries. It returns one chosen order statistic of the window, by default the median. The window is held as a row of cells sorted by magnitude. Each cell keeps a sample and an age tag. On every accepted sample, the cell whose tag marks it as the oldest is vacated. The cells between the vacated slot and the insertion point then slide one place toward it. The new sample drops into the gap. Each cell decides its own move from its own comparison and its neighbours' comparisons, so an insertion takes one clock cycle and no full sort ever runs.

The selected rank is a parameter: the median by default, or a lower or higher rank for impulse-biased or brightness-style filtering. Samples can be compared as unsigned or two's complement values. For two-dimensional use, a group length parameter marks only every `GROUP_LEN`-th result as valid, so a column of pixels can be pushed in before one output is taken. After reset, the window is preloaded with zero samples. Output valid stays low until a full window of real samples has arrived.

Top module: `rank_order_filter`

## Requirements
- R1: After every clock edge, the cell values are in non-decreasing order from cell 0 to cell `2*HALF_WIN`, under the comparison chosen by `SIGNED`.
- R2: Each accepted sample (`in_valid` high at a rising edge) evicts the oldest sample in the window, wherever it sits. One sample is accepted per cycle, back to back. The window therefore always holds the last `2*HALF_WIN+1` accepted samples, with the zero preload counting as older than all of them.
- R3: The age tags of the cells are always a permutation of `0..2*HALF_WIN`. Exactly one cell carries the eviction age `2*HALF_WIN`.
- R4: `out_data` equals the `RANK`-th smallest window value, with 0 meaning the smallest. The default `RANK` is `HALF_WIN`, which gives the median.
- R5: With `SIGNED=1`, values are ordered as two's complement numbers, so a value with the top bit set sorts below every value with the top bit clear. With `SIGNED=0`, they are ordered as unsigned numbers.
- R6: `out_valid` is a one-cycle pulse in the cycle after the sample that produced it. It stays low until the `2*HALF_WIN+1`-th accepted sample after reset.
- R7: When `GROUP_LEN` is G, `out_valid` pulses only for accepted samples whose count since reset (counting from 1) is a multiple of G and is at least `2*HALF_WIN+1`.
- R8: In a cycle without `in_valid`, the window does not change: `out_data` is unchanged at the next edge and `out_valid` is low.
- R9: After reset, `out_valid` is low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_data` for acceptance this cycle |
| in_data | input | DATA_W | New sample |
| out_valid | output | 1 | Marks `out_data` as a result for the last accepted sample |
| out_data | output | DATA_W | Selected rank of the current window |

## Verification
A broken age tag evicts the wrong sample. Because the bench checks `out_data` after every accepted sample against a history model, this shows within at most one window of inputs, when the surviving mix of values differs from the model's. A misplaced insertion breaks the ordering of the cells. The ordering assertion catches that in the same cycle, and the port shows a wrong rank as soon as the disordered cell reaches the selected position. Valid-timing faults appear in the first window after reset and at group boundaries, which the grouped instance checks on every sample.

// File: rtl/rof_pkg.sv
package rof_pkg;

  typedef enum logic [1:0] {
    MV_INSERT     = 2'd0,
    MV_HOLD       = 2'd1,
    MV_FROM_LEFT  = 2'd2,
    MV_FROM_RIGHT = 2'd3
  } move_e;

  // Ordering key: flipping the sign bit turns a two's complement order
  // into an unsigned one, so one comparator serves both encodings.
  function automatic logic key_less(input logic [31:0] a, input logic [31:0] b,
                                    input bit sgn, input int w);
    logic [31:0] flip;
    flip = sgn ? (32'd1 << (w - 1)) : 32'd0;
    return (a ^ flip) < (b ^ flip);
  endfunction

  // Bits needed to tag ages 0..win-1.
  function automatic int age_width(input int win);
    return (win <= 2) ? 1 : $clog2(win);
  endfunction

endpackage

// File: rtl/rof_age_scan.sv
module rof_age_scan #(
  parameter int WIN   = 5,
  parameter int AGE_W = 3
) (
  input  logic [AGE_W-1:0] ages [WIN],
  output logic [WIN-1:0]   is_old,
  output logic [WIN-1:0]   at_or_left,
  output logic [WIN-1:0]   at_or_right
);

  localparam logic [AGE_W-1:0] EVICT_AGE = AGE_W'(WIN - 1);

  genvar gi;
  generate
    for (gi = 0; gi < WIN; gi++) begin : g_flag
      assign is_old[gi] = (ages[gi] == EVICT_AGE);
    end
  endgenerate

  // Prefix and suffix OR chains tell each cell on which side the evicted
  // entry lies.
  always_comb begin
    at_or_left[0] = is_old[0];
    for (int i = 1; i < WIN; i++) begin
      at_or_left[i] = at_or_left[i-1] | is_old[i];
    end
    at_or_right[WIN-1] = is_old[WIN-1];
    for (int i = WIN - 2; i >= 0; i--) begin
      at_or_right[i] = at_or_right[i+1] | is_old[i];
    end
  end

endmodule

// File: rtl/rof_cell.sv
module rof_cell
  import rof_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int AGE_W     = 3,
  parameter int SIGNED    = 0,
  parameter int RESET_AGE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] new_sample,
  input  logic [DATA_W-1:0] left_val,
  input  logic [AGE_W-1:0]  left_age,
  input  logic              left_lt,
  input  logic [DATA_W-1:0] right_val,
  input  logic [AGE_W-1:0]  right_age,
  input  logic              right_lt,
  input  logic              old_here,
  input  logic              old_at_or_left,
  input  logic              old_at_or_right,
  output logic [DATA_W-1:0] cell_val,
  output logic [AGE_W-1:0]  cell_age,
  output logic              cell_lt
);

  logic  old_strict_right;
  logic  old_strict_left;
  logic  take_right;
  logic  take_left;
  logic  keep;
  move_e move;

  assign cell_lt = key_less(32'(cell_val), 32'(new_sample), SIGNED != 0, DATA_W);

  assign old_strict_right = old_at_or_right & ~old_here;
  assign old_strict_left  = old_at_or_left  & ~old_here;

  // Cells at or beyond the vacancy pull from the right while the right
  // neighbour is below the new sample; cells at or before it pull from
  // the left while the left neighbour is not below it.
  assign take_right = old_at_or_left  & right_lt;
  assign take_left  = old_at_or_right & ~left_lt;
  // Left of the vacancy a smaller value stays; right of it a not-smaller one.
  assign keep       = (old_strict_right & cell_lt) | (old_strict_left & ~cell_lt);

  always_comb begin
    if (take_right)     move = MV_FROM_RIGHT;
    else if (take_left) move = MV_FROM_LEFT;
    else if (keep)      move = MV_HOLD;
    else                move = MV_INSERT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_val <= '0;
      cell_age <= AGE_W'(RESET_AGE);
    end else if (shift_en) begin
      unique case (move)
        MV_FROM_RIGHT: begin
          cell_val <= right_val;
          cell_age <= right_age + 1'b1;
        end
        MV_FROM_LEFT: begin
          cell_val <= left_val;
          cell_age <= left_age + 1'b1;
        end
        MV_HOLD: begin
          cell_age <= cell_age + 1'b1;
        end
        default: begin
          cell_val <= new_sample;
          cell_age <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/rof_out_seq.sv
module rof_out_seq #(
  parameter int WIN       = 5,
  parameter int GROUP_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic out_valid
);

  localparam int FILL_W  = $clog2(WIN + 1);
  localparam int GROUP_W = $clog2(GROUP_LEN + 1);
  localparam logic [FILL_W-1:0]  FILL_LAST  = FILL_W'(WIN - 1);
  localparam logic [GROUP_W-1:0] GROUP_LAST = GROUP_W'(GROUP_LEN - 1);

  logic [FILL_W-1:0]  fill_cnt;
  logic [GROUP_W-1:0] group_cnt;
  logic               window_full;
  logic               group_end;

  assign window_full = (fill_cnt == FILL_LAST);
  assign group_end   = (group_cnt == GROUP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      group_cnt <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid & window_full & group_end;
      if (in_valid) begin
        if (!window_full) fill_cnt <= fill_cnt + 1'b1;
        group_cnt <= group_end ? '0 : group_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rank_order_filter.sv
module rank_order_filter
  import rof_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HALF_WIN  = 2,
  parameter int SIGNED    = 0,
  parameter int RANK      = HALF_WIN,
  parameter int GROUP_LEN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int WIN   = 2 * HALF_WIN + 1;
  localparam int AGE_W = age_width(WIN);

  logic [DATA_W-1:0] pe_val [WIN];
  logic [AGE_W-1:0]  pe_age [WIN];
  logic [WIN-1:0]    pe_lt;
  logic [WIN-1:0]    is_old;
  logic [WIN-1:0]    old_at_or_left;
  logic [WIN-1:0]    old_at_or_right;

  rof_age_scan #(
    .WIN   (WIN),
    .AGE_W (AGE_W)
  ) u_scan (
    .ages        (pe_age),
    .is_old      (is_old),
    .at_or_left  (old_at_or_left),
    .at_or_right (old_at_or_right)
  );

  genvar gi;
  generate
    for (gi = 0; gi < WIN; gi++) begin : g_cell
      logic [DATA_W-1:0] lval;
      logic [AGE_W-1:0]  lage;
      logic              llt;
      logic [DATA_W-1:0] rval;
      logic [AGE_W-1:0]  rage;
      logic              rlt;

      if (gi == 0) begin : g_lo_edge
        assign lval = '0;
        assign lage = '0;
        assign llt  = 1'b1;
      end else begin : g_lo_link
        assign lval = pe_val[gi-1];
        assign lage = pe_age[gi-1];
        assign llt  = pe_lt[gi-1];
      end

      if (gi == WIN - 1) begin : g_hi_edge
        assign rval = '0;
        assign rage = '0;
        assign rlt  = 1'b0;
      end else begin : g_hi_link
        assign rval = pe_val[gi+1];
        assign rage = pe_age[gi+1];
        assign rlt  = pe_lt[gi+1];
      end

      rof_cell #(
        .DATA_W    (DATA_W),
        .AGE_W     (AGE_W),
        .SIGNED    (SIGNED),
        .RESET_AGE (gi)
      ) u_cell (
        .clk             (clk),
        .rst_n           (rst_n),
        .shift_en        (in_valid),
        .new_sample      (in_data),
        .left_val        (lval),
        .left_age        (lage),
        .left_lt         (llt),
        .right_val       (rval),
        .right_age       (rage),
        .right_lt        (rlt),
        .old_here        (is_old[gi]),
        .old_at_or_left  (old_at_or_left[gi]),
        .old_at_or_right (old_at_or_right[gi]),
        .cell_val        (pe_val[gi]),
        .cell_age        (pe_age[gi]),
        .cell_lt         (pe_lt[gi])
      );
    end
  endgenerate

  rof_out_seq #(
    .WIN       (WIN),
    .GROUP_LEN (GROUP_LEN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid)
  );

  assign out_data = pe_val[RANK];

endmodule

// File: rtl/rank_order_filter_chk.sv
module rank_order_filter_chk
  import rof_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIN    = 5,
  parameter int AGE_W  = 3,
  parameter int SIGNED = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W-1:0] pe_val [WIN],
  input logic [AGE_W-1:0]  pe_age [WIN],
  input logic [WIN-1:0]    is_old
);

  localparam int SEEN_W = $clog2(WIN + 1);

  logic              sorted_ok;
  logic [WIN-1:0]    age_seen;
  logic [SEEN_W-1:0] seen;

  always_comb begin
    sorted_ok = 1'b1;
    for (int i = 0; i < WIN - 1; i++) begin
      if (key_less(32'(pe_val[i+1]), 32'(pe_val[i]), SIGNED != 0, DATA_W)) sorted_ok = 1'b0;
    end
  end

  always_comb begin
    age_seen = '0;
    for (int i = 0; i < WIN; i++) begin
      if (int'(pe_age[i]) < WIN) age_seen[pe_age[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != SEEN_W'(WIN)) seen <= seen + 1'b1;
  end

  a_r1_cells_sorted: assert property (@(posedge clk) disable iff (!rst_n)
    sorted_ok);

  a_r3_ages_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    &age_seen);

  a_r3_one_evict_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_old) == 1);

  a_r6_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r6_no_valid_before_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen == SEEN_W'(WIN)));

  a_r8_idle_keeps_output: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && !out_valid));

endmodule

bind rank_order_filter rank_order_filter_chk #(
  .DATA_W (DATA_W),
  .WIN    (WIN),
  .AGE_W  (AGE_W),
  .SIGNED (SIGNED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .pe_val    (pe_val),
  .pe_age    (pe_age),
  .is_old    (is_old)
);

// File: tb/tb_rank_order_filter.sv
`timescale 1ns/1ps
module tb_rank_order_filter;

  localparam int DW  = 4;
  localparam int HW  = 2;
  localparam int W   = 2 * HW + 1;
  localparam int GRP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          ov_u, ov_s, ov_g;
  logic [DW-1:0] od_u, od_s, od_g;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  int  hist[$];
  int  seen = 0;
  bit  first = 1;

  logic          ev_u, ev_s, ev_g;
  logic [DW-1:0] ed_u, ed_s, ed_g;

  always #2.5 clk = ~clk;

  rank_order_filter #(.DATA_W(DW), .HALF_WIN(HW), .SIGNED(0), .RANK(HW), .GROUP_LEN(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov_u), .out_data(od_u));

  rank_order_filter #(.DATA_W(DW), .HALF_WIN(HW), .SIGNED(1), .RANK(1), .GROUP_LEN(1)) dut_sgn (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov_s), .out_data(od_s));

  rank_order_filter #(.DATA_W(DW), .HALF_WIN(HW), .SIGNED(0), .RANK(3), .GROUP_LEN(GRP)) dut_grp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov_g), .out_data(od_g));

  function automatic int key_of(input int v, input bit sgn);
    return (sgn && v >= (1 << (DW - 1))) ? v - (1 << DW) : v;
  endfunction

  // Rank r of the history window, sorted by the chosen encoding.
  function automatic logic [DW-1:0] rank_of(input bit sgn, input int r);
    int a[W];
    for (int i = 0; i < W; i++) a[i] = hist[i];
    for (int i = 1; i < W; i++) begin
      int t = a[i];
      int j = i - 1;
      while (j >= 0 && key_of(a[j], sgn) > key_of(t, sgn)) begin
        a[j+1] = a[j];
        j--;
      end
      a[j+1] = t;
    end
    return DW'(a[r]);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (sample %0d)", tag, act, exp, seen);
    end
  endtask

  task automatic check_outputs();
    if (first) begin
      check("R9 valid after reset (dut)", DW'(ov_u), DW'(ev_u));
      check("R9 data after reset (dut)", od_u, ed_u);
      check("R9 valid after reset (dut_sgn)", DW'(ov_s), DW'(ev_s));
      check("R9 data after reset (dut_grp)", od_g, ed_g);
      first = 0;
    end else begin
      check("R6 R8 out_valid unsigned median", DW'(ov_u), DW'(ev_u));
      check("R2 R4 R8 unsigned median data", od_u, ed_u);
      check("R5 R6 out_valid signed rank 1", DW'(ov_s), DW'(ev_s));
      check("R5 R2 signed rank 1 data", od_s, ed_s);
      check("R7 out_valid grouped", DW'(ov_g), DW'(ev_g));
      check("R4 R2 rank 3 data grouped", od_g, ed_g);
    end
  endtask

  task automatic drive(input bit v, input int d);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_data  = DW'(d);
    if (v) begin
      hist.push_back(d % (1 << DW));
      void'(hist.pop_front());
      seen++;
      ev_u = (seen >= W);
      ev_s = (seen >= W);
      ev_g = (seen >= W) && (seen % GRP == 0);
      ed_u = rank_of(0, HW);
      ed_s = rank_of(1, 1);
      ed_g = rank_of(0, 3);
    end else begin
      ev_u = 0;
      ev_s = 0;
      ev_g = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < W; i++) hist.push_back(0);
    ev_u = 0; ev_s = 0; ev_g = 0;
    ed_u = '0; ed_s = '0; ed_g = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Ascending sweep over every code, several laps (R2, R4, R6, R7)
    for (int lap = 0; lap < 3; lap++)
      for (int v = 0; v < (1 << DW); v++) drive(1, v);
    // Descending sweep
    for (int lap = 0; lap < 2; lap++)
      for (int v = (1 << DW) - 1; v >= 0; v--) drive(1, v);
    // Constant runs: ties everywhere
    for (int v = 0; v < (1 << DW); v += 5)
      for (int n = 0; n < 2 * W; n++) drive(1, v);
    // Sign boundary and extremes alternating (R5)
    for (int n = 0; n < 40; n++) drive(1, (n % 2) ? 8 : 7);
    for (int n = 0; n < 40; n++) drive(1, (n % 3 == 0) ? 15 : 0);
    // Idle cycles keep the window unchanged (R8)
    for (int n = 0; n < 6; n++) drive(0, 9);
    // Every pair of codes, each followed by a pseudo-random filler
    lfsr = 8'h5a;
    for (int a = 0; a < (1 << DW); a++)
      for (int b = 0; b < (1 << DW); b++) begin
        drive(1, a);
        drive(1, b);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        drive(lfsr[0] | lfsr[1], int'(lfsr[7:4]));
      end
    drive(0, 0);
    drive(0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule